// File: doc/BRIEF.md
# Tap-Hopping LFSR Code Generator

This block produces an 8-bit pseudo-random code vector from an 8-stage linear feedback shift register whose feedback polynomial does not stay fixed. Seven maximal-length tap sets are available. A parity network computes the feedback bit for every tap set in parallel, and an 8-to-1 multiplexer passes one of those bits to the register input. The multiplexer select comes from a small 3-bit PN generator. That generator steps only when a divide-by-N counter wraps, so each tap set stays in force for N consecutive steps before the polynomial changes.

The resulting sequence depends on three things: the main seed, the starting state of the select generator, and the divide value. A synchronous preset loads the seed and restarts the select generator and the divider. A scrambler and a descrambler can each hold one copy of the block. Presetting both with the same seed and divide value makes them produce the same code stream on every clock.

Top module: `hopcode_gen`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is asserted, `code` reads 8'hFF.
- R2: A clock edge with `preset` high loads `code` with `seed` when `seed` is nonzero. The same edge sets the select state to 3'b111 and the divider count to 0.
- R3: A clock edge with `preset` high and `seed` equal to 8'h00 loads `code` with 8'hFF instead.
- R4: Every clock edge with `preset` low, after reset, shifts `code` one place toward bit 0. Bit 7 then takes the feedback bit, which is the XOR of the bits of `code` selected by the active tap mask. The tap masks, indexed by select state, are: 1:8'h8D, 2:8'h65, 3:8'h4D, 4:8'h69, 5:8'h2D, 6:8'h1D, and 7 and 0:8'h71. A mask bit i includes `code[i]`.
- R5: After a preset with seed 8'hFF, successive clocks give `code` = 8'h7F, 8'h3F, 8'h9F, 8'h4F.
- R6: The select state steps as next = {s[1:0], s[2]^s[1]}. Starting from 3'b111 it visits 7, 6, 4, 1, 2, 5, 3 and repeats, and it is never 0.
- R7: The select state advances on the edge that completes each run of N steps after a preset, where N is `div_n`. A `div_n` of 0 behaves as 1.
- R8: Two presets with the same `seed` and `div_n` produce identical `code` streams afterwards.
- R9: With `div_n` = 255, each of the seven tap sets is held for 255 steps. Within each such window `code` returns to its window-start value after exactly 255 steps and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| preset | input | 1 | Synchronous preset: load seed, restart select generator and divider |
| seed | input | 8 | Main register seed (zero replaced by all ones) |
| div_n | input | DIV_W | Number of steps each tap set is held (0 treated as 1) |
| code | output | 8 | Current code vector |

## Verification
`code` is a register, so it shows the effect of a preset or a step one clock edge after that edge samples the inputs. The bench drives inputs and samples outputs on falling edges, and after every rising edge it advances its own arithmetic model by exactly one step before comparing. A change of select state first affects the feedback on the edge after the divider wraps. The model applies the same rule: the step uses the old select state, and the select state is advanced afterwards. Reset release passes through two synchronizer stages, so the bench applies a preset before it compares any stepping.

// File: rtl/hop_pkg.sv
package hop_pkg;
  localparam int CODE_W = 8;
  localparam int SEL_W  = 3;
  localparam int NSETS  = 1 << SEL_W;

  // Feedback mask per select value; bit i picks code[i].
  function automatic logic [CODE_W-1:0] tap_mask(input logic [SEL_W-1:0] s);
    case (s)
      3'd1:    tap_mask = 8'h8D;
      3'd2:    tap_mask = 8'h65;
      3'd3:    tap_mask = 8'h4D;
      3'd4:    tap_mask = 8'h69;
      3'd5:    tap_mask = 8'h2D;
      3'd6:    tap_mask = 8'h1D;
      default: tap_mask = 8'h71;
    endcase
  endfunction
endpackage

// File: rtl/hop_rst_sync.sv
module hop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_q_n = stg_q[1];
endmodule

// File: rtl/hop_divider.sv
module hop_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] last;

  always_comb begin
    last  = (div_n == '0) ? '0 : div_n - 1'b1;
    tick  = !preset && (cnt_q >= last);
    if (preset)    cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hop_sel_lfsr.sv
module hop_sel_lfsr
  import hop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preset,
  input  logic             adv_en,
  output logic [SEL_W-1:0] sel
);
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    if (preset)      sel_d = '1;
    else if (adv_en) sel_d = {sel_q[1:0], sel_q[2] ^ sel_q[1]};
    else             sel_d = sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_d;
  end

  assign sel = sel_q;
endmodule

// File: rtl/hop_main_lfsr.sv
module hop_main_lfsr
  import hop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic [CODE_W-1:0] seed,
  input  logic [SEL_W-1:0]  sel,
  output logic [CODE_W-1:0] state
);
  logic [CODE_W-1:0] st_q, st_d;
  logic [NSETS-1:0]  fb_vec;
  logic              fb;

  for (genvar g = 0; g < NSETS; g++) begin : g_par
    assign fb_vec[g] = ^(st_q & tap_mask(g[SEL_W-1:0]));
  end

  always_comb begin
    fb = fb_vec[sel];
    if (preset) st_d = (seed == '0) ? '1 : seed;
    else        st_d = {fb, st_q[CODE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/hopcode_gen.sv
module hopcode_gen
  import hop_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic [CODE_W-1:0] seed,
  input  logic [DIV_W-1:0]  div_n,
  output logic [CODE_W-1:0] code
);
  logic             rst_q_n;
  logic             tick;
  logic [SEL_W-1:0] sel_q;

  hop_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  hop_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_q_n), .preset(preset), .div_n(div_n), .tick(tick)
  );

  hop_sel_lfsr u_sel (
    .clk(clk), .rst_n(rst_q_n), .preset(preset), .adv_en(tick), .sel(sel_q)
  );

  hop_main_lfsr u_main (
    .clk(clk), .rst_n(rst_q_n), .preset(preset), .seed(seed),
    .sel(sel_q), .state(code)
  );
endmodule

// File: rtl/hopcode_chk.sv
module hopcode_chk
  import hop_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              preset,
  input logic [CODE_W-1:0] seed,
  input logic [SEL_W-1:0]  sel,
  input logic [CODE_W-1:0] code
);
  // R2
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset && seed != '0) |=> (code == $past(seed)));

  // R3
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (preset && seed == '0) |=> (code == 8'hFF));

  // R4
  shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !preset |=> (code[CODE_W-2:0] == $past(code[CODE_W-1:1])));

  // R6
  sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sel != '0);

  // R6
  sel_after_preset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    preset |=> (sel == 3'b111));
endmodule

bind hopcode_gen hopcode_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .preset(preset), .seed(seed),
  .sel(sel_q), .code(code)
);

// File: tb/sim_hopcode_gen.sv
module sim_hopcode_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       preset = 1'b0;
  logic [7:0] seed = 8'h00;
  logic [7:0] div_n = 8'd1;
  logic [7:0] code;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  logic [7:0] m;
  logic [2:0] s;
  int         c;
  int         nv;

  hopcode_gen #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .preset(preset), .seed(seed),
    .div_n(div_n), .code(code)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] mask_of(input logic [2:0] v);
    case (v)
      3'd1: return 8'h8D;
      3'd2: return 8'h65;
      3'd3: return 8'h4D;
      3'd4: return 8'h69;
      3'd5: return 8'h2D;
      3'd6: return 8'h1D;
      default: return 8'h71;
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: code=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic fb;
    int lim;
    fb  = ^(m & mask_of(s));
    m   = {fb, m[7:1]};
    lim = (nv == 0) ? 1 : nv;
    if (c >= lim - 1) begin
      c = 0;
      s = {s[1:0], s[2] ^ s[1]};
    end else c++;
  endtask

  task automatic do_preset(input logic [7:0] sd, input logic [7:0] n);
    @(negedge clk);
    preset = 1'b1; seed = sd; div_n = n;
    @(negedge clk);
    preset = 1'b0;
    m = (sd == 8'h00) ? 8'hFF : sd;
    s = 3'b111; c = 0; nv = n;
  endtask

  task automatic run_steps(input string req, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      model_step();
      check8(req, code, m);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: code=%h expected=done", code);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rec [0:39];
    logic [7:0] st;
    // R1: reset value
    repeat (3) @(negedge clk);
    check8("R1", code, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: documented sequence from all-ones seed
    do_preset(8'hFF, 8'd200);
    check8("R2", code, 8'hFF);
    @(negedge clk); check8("R5", code, 8'h7F);
    @(negedge clk); check8("R5", code, 8'h3F);
    @(negedge clk); check8("R5", code, 8'h9F);
    @(negedge clk); check8("R5", code, 8'h4F);

    // R3: zero seed
    do_preset(8'h00, 8'd3);
    check8("R3", code, 8'hFF);
    run_steps("R4", 20);

    // R2: several seeds
    do_preset(8'hA5, 8'd4);
    check8("R2", code, 8'hA5);
    do_preset(8'h01, 8'd4);
    check8("R2", code, 8'h01);
    do_preset(8'h80, 8'd4);
    check8("R2", code, 8'h80);

    // R4 R6 R7: sweep divide values
    foreach (rec[i]) rec[i] = 8'h00;
    for (int n = 0; n < 10; n++) begin
      do_preset(8'h3C + 8'(n), 8'(n));
      run_steps("R7", 70);
    end
    do_preset(8'hC3, 8'd13);
    run_steps("R6", 120);

    // R8: repeat presets give the same stream
    do_preset(8'h5A, 8'd6);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rec[i] = code;
    end
    do_preset(8'h5A, 8'd6);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check8("R8", code, rec[i]);
    end

    // R9: each tap set held for 255 steps has period 255
    do_preset(8'h9E, 8'd255);
    for (int w = 0; w < 7; w++) begin
      st = m;
      for (int i = 1; i <= 255; i++) begin
        @(negedge clk);
        model_step();
        if (i < 255) begin
          if (code === st) begin
            nchk++; nfail++;
            $display("FAIL R9: code=%h expected=not %h at step %0d", code, st, i);
          end
        end else check8("R9", code, st);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule